// File: doc/BRIEF.md
# Self-Starting Toggle-Flop Sequence Counter

This block is a three-bit synchronous counter. Its state sits in three toggle flip-flops, called A (the most significant bit), B and C. Fixed toggle-enable equations step the counter through the non-binary cycle 0, 1, 5, 2, 4, 3 and then back to 0. The two codes outside that cycle, 6 and 7, return to it on the next advance, so the counter needs no start-up logic. It suits sequencing or scrambling jobs where a short fixed, non-monotonic order is wanted and a corrupted state must clear itself.

Each flip-flop inverts on a rising clock edge when its toggle enable is 1 and the advance input is high; otherwise it holds. The enables are:

- tA = A | (B ^ C)
- tB = A | B
- tC = A | ~(B ^ C)

A synchronous clear drives the state to 000 and wins over advance. The asynchronous active-low reset is asserted at once and released through a synchronizer. It loads a parameter value (000 by default). That parameter also lets the two codes outside the cycle be used as start states.

Top module: `tseq_counter`

## Requirements
- R1: While the asynchronous reset input is low, the state output equals the INIT_STATE parameter (default 3'b000), with no clock edge needed.
- R2: A rising edge with the clear input high leaves the state at 3'b000, whatever the advance input and the current state.
- R3: A rising edge with clear low and advance low leaves the state unchanged.
- R4: With advance high and clear low, the state steps 0→1→5→2→4→3→0, the state written as the unsigned value of {A,B,C}.
- R5: With advance high and clear low, state 7 goes to 0.
- R6: With advance high and clear low, state 6 goes to 1 and then follows the R4 cycle.
- R7: When A (state bit 2) is 1 and the counter advances, all three bits invert, so the next state is the bitwise complement.
- R8: From any of the 8 states, at most 6 advances reach state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear to 000, takes priority over advance |
| adv_i | input | 1 | Advance enable; when low the state holds |
| state_o | output | 3 | Current state {A,B,C} |

## Verification
Clear and advance can both be high in the same cycle. The bench raises both together while eight counters, one started from each of the eight states, sit at different points of their paths. After that edge every one of them must read 000, since clear wins. The bench also holds clear high with advance low, and steps advance alone from every state, so that each function is also seen by itself.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int unsigned CNT_W      = 3;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } abc_t;
endpackage

// File: rtl/tseq_rst_sync.sv
module tseq_rst_sync #(
  parameter int unsigned DEPTH = tseq_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[DEPTH-1];
endmodule

// File: rtl/tseq_tlogic.sv
module tseq_tlogic
  import tseq_pkg::*;
(
  input  abc_t cur_i,
  output abc_t tgl_o
);
  logic bc_diff;

  always_comb begin
    bc_diff   = cur_i.b ^ cur_i.c;
    tgl_o.a   = cur_i.a | bc_diff;
    tgl_o.b   = cur_i.a | cur_i.b;
    tgl_o.c   = cur_i.a | ~bc_diff;
  end

  // Full inversion whenever the top bit is set
  always_comb begin
    if (cur_i.a) begin
      p_a_all_r7: assert (tgl_o == 3'b111);
    end
  end
endmodule

// File: rtl/tseq_tff.sv
module tseq_tff #(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic ce;

  always_comb begin
    ce  = clr_i | en_i;
    q_d = q_q;
    if (clr_i)      q_d = 1'b0;
    else if (en_i)  q_d = ~q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= INIT;
    else if (ce)  q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tseq_counter.sv
module tseq_counter
  import tseq_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_STATE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] state_o
);
  logic             rst_sync_n;
  abc_t             cur;
  abc_t             tgl;
  logic [CNT_W-1:0] tgl_vec;
  logic [CNT_W-1:0] en_vec;
  logic [CNT_W-1:0] q_vec;

  tseq_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rsync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tseq_tlogic u_tlogic (
    .cur_i (cur),
    .tgl_o (tgl)
  );

  always_comb begin
    cur     = q_vec;
    tgl_vec = tgl;
    en_vec  = tgl_vec & {CNT_W{adv_i}};
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    tseq_tff #(.INIT(INIT_STATE[i])) u_tff (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .clr_i  (clr_i),
      .en_i   (en_vec[i]),
      .q_o    (q_vec[i])
    );
  end

  assign state_o = q_vec;

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    clr_i |=> state_o == 3'd0);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!clr_i && !adv_i) |=> $stable(state_o));

  p_zero_to_one_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (adv_i && !clr_i && state_o == 3'd0) |=> state_o == 3'd1);

  p_three_to_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (adv_i && !clr_i && state_o == 3'd3) |=> state_o == 3'd0);

  p_seven_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (adv_i && !clr_i && state_o == 3'd7) |=> state_o == 3'd0);

  p_six_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (adv_i && !clr_i && state_o == 3'd6) |=> state_o == 3'd1);
endmodule

// File: tb/tseq_counter_test.sv
module tseq_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic adv;
  logic [2:0] st_main;
  logic [2:0] st_s [8];
  logic [2:0] model [8];
  logic       seen0 [8];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tseq_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .adv_i(adv), .state_o(st_main)
  );

  for (genvar k = 0; k < 8; k++) begin : g_seed
    tseq_counter #(.INIT_STATE(3'(k))) u_s (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .adv_i(adv), .state_o(st_s[k])
    );
  end

  function automatic logic [2:0] nxt(input logic [2:0] s);
    if (s[2]) return ~s;
    case (s)
      3'd0:    return 3'd1;
      3'd1:    return 3'd5;
      3'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    if (s == 3'd7) return "R5";
    if (s == 3'd6) return "R6";
    if (s[2])      return "R7";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; clr = 1'b0; adv = 1'b0;
    #1 rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1: reset values
    check("R1", st_main, 3'd0);
    for (int k = 0; k < 8; k++) check("R1", st_s[k], 3'(k));
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    // R3: hold with advance low
    for (int k = 0; k < 8; k++) check("R3", st_s[k], 3'(k));

    // One advance from every state, then follow paths
    for (int k = 0; k < 8; k++) begin
      model[k] = 3'(k);
      seen0[k] = (k == 0);
    end
    adv = 1'b1;
    for (int n = 0; n < 6; n++) begin
      step();
      for (int k = 0; k < 8; k++) begin
        check(tag_of(model[k]), st_s[k], nxt(model[k]));
        model[k] = nxt(model[k]);
        if (model[k] == 3'd0 && st_s[k] == 3'd0) seen0[k] = 1'b1;
      end
    end
    // R8: every start reached 0 within 6 advances
    for (int k = 0; k < 8; k++) check("R8", 3'(seen0[k]), 3'd1);

    // R3: hold mid-path
    adv = 1'b0;
    step();
    for (int k = 0; k < 8; k++) check("R3", st_s[k], model[k]);

    // R2: clear and advance together
    adv = 1'b1;
    step();
    for (int k = 0; k < 8; k++) model[k] = nxt(model[k]);
    clr = 1'b1;
    step();
    for (int k = 0; k < 8; k++) check("R2", st_s[k], 3'd0);
    check("R2", st_main, 3'd0);
    // R2: clear alone from a non-zero state
    clr = 1'b0;
    step(); step();
    check("R4", st_main, 3'd5);
    clr = 1'b1; adv = 1'b0;
    step();
    check("R2", st_main, 3'd0);
    clr = 1'b0; adv = 1'b1;

    // R4: main cycle over two full turns, with a pause
    begin
      logic [2:0] m;
      m = 3'd0;
      for (int n = 0; n < 12; n++) begin
        if (n == 7) begin
          adv = 1'b0;
          step();
          check("R3", st_main, m);
          adv = 1'b1;
        end
        step();
        m = nxt(m);
        check("R4", st_main, m);
      end
    end

    // R1: asynchronous reset mid-run, no edge needed
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    for (int k = 0; k < 8; k++) check("R1", st_s[k], 3'(k));
    rst_n = 1'b1;
    finish_run();
  end
endmodule